// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide flash memory controller. It watches write cycles on the host bus and picks out the unlock-prefixed command sequences. From them it issues single-cycle start strobes to a byte program engine and a block erase engine, and it decides what a host read returns: the array byte, an identifier byte, or a per-sector protection flag. A seven-bit protection mask keeps program and erase away from locked sectors. The array itself sits outside the block as a plain read port, and the two engines report completion through done pulses.

Any write that does not continue a valid sequence sends the decoder back to read mode. While an engine is working, writes are ignored. A running sector erase can be put on hold so that bytes in sectors outside its erase list can be read and programmed, and it can then be resumed.

Top module: `flashCmdSeq`

## Requirements
- R1: After reset the decoder is in read mode: `busy`, `eraseHold`, `progStart` and `eraseStart` are 0, and `rdData` equals `arrayRdData`.
- R2: The write sequence (low 12 address bits 555h, AAh), (2AAh, 55h), (555h, A0h), (A, D) to an unprotected sector raises `progStart` for the one cycle after the last write, with `progAddr` = A.
- R3: `progData` equals D AND the array byte at A, so a program only clears bits. Once the program engine finishes, a read of A returns that value.
- R4: A write whose address or data does not match the next step of any sequence returns the decoder to read mode, and the steps that follow issue no start strobe.
- R5: After (555h,AAh), (2AAh,55h), (555h,90h), reads return a byte chosen by address bits 7:0: 00h gives 04h, 01h gives the device code (default A7h), 02h gives 01h if the addressed sector is protected and 00h if it is not. The mode ends with a write of F0h at any address.
- R6: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), (555h,10h) raises `eraseStart` for one cycle, with `eraseMask` = ~`protMask`.
- R7: The same five-write prefix followed by 30h at any address in a sector puts that sector in the erase list. Each further 30h write within ERASE_WIN cycles adds a sector and restarts the window. When the window expires, `eraseStart` pulses with `eraseMask` = list AND ~`protMask`. Any other write inside the window cancels the erase. Sector map, by address: 0 = 00000h–03FFFh, 1 = 04000h–05FFFh, 2 = 06000h–07FFFh, 3 = 08000h–0FFFFh, 4 = 1xxxxh, 5 = 2xxxxh, 6 = 3xxxxh. Bit s of the masks stands for sector s.
- R8: A program to a protected sector, or an erase in which every selected sector is protected, issues no start strobe and leaves the array unchanged.
- R9: While a program or erase is running, `busy` is 1 and writes are ignored. On the engine's done pulse the decoder returns to read mode.
- R10: A write of B0h at any address during a running sector erase sets `eraseHold` to 1. The same write during a chip erase has no effect.
- R11: While on hold, the program sequence is accepted only for an unprotected sector outside the erase list, and the decoder stays on hold while that program runs. A write of 30h clears `eraseHold` so the erase can finish.
- R12: Driving `rstN` low during any operation aborts it: `busy` and `eraseHold` drop to 0 and the decoder is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, asynchronous |
| wrEn | input | 1 | A host write is sampled on this clock edge |
| addr | input | 18 | Host byte address, used for both reads and writes |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data returned to the host |
| arrayRdData | input | 8 | Array byte at `addr` |
| protMask | input | 7 | Per-sector protection, 1 = locked |
| progStart | output | 1 | Program engine start strobe |
| progAddr | output | 18 | Byte address for the program engine |
| progData | output | 8 | Byte value for the program engine |
| progDone | input | 1 | Program engine finished |
| eraseStart | output | 1 | Erase engine start strobe |
| eraseMask | output | 7 | Sectors the erase engine must clear |
| eraseDone | input | 1 | Erase engine finished |
| eraseHold | output | 1 | Erase engine must pause |
| busy | output | 1 | An embedded operation is pending |

## Verification
The hardest state to reach is a program issued while a sector erase is on hold. The bench has to finish a six-write erase sequence, let the accumulation window expire, and land a B0h write while its engine model is still counting. Only then can it send the program sequence to one sector in the erase list and to one outside it. The bench engine pauses while `eraseHold` is set, so the array result after resuming shows both the hold and the rejected program. Random programs with random protection masks and broken unlock sequences are mixed in.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 8;
  localparam int NUM_SECT = 7;
  localparam int SECT_W   = $clog2(NUM_SECT);
  localparam int CMP_W    = 12;

  localparam logic [CMP_W-1:0]  UNL_ADDR1 = 12'h555;
  localparam logic [CMP_W-1:0]  UNL_ADDR2 = 12'h2AA;
  localparam logic [DATA_W-1:0] UNL_DATA1 = 8'hAA;
  localparam logic [DATA_W-1:0] UNL_DATA2 = 8'h55;
  localparam logic [DATA_W-1:0] OP_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] OP_ERASE  = 8'h80;
  localparam logic [DATA_W-1:0] OP_IDENT  = 8'h90;
  localparam logic [DATA_W-1:0] OP_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] OP_SECT   = 8'h30;
  localparam logic [DATA_W-1:0] OP_HOLD   = 8'hB0;
  localparam logic [DATA_W-1:0] OP_RESET  = 8'hF0;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PSETUP, ST_ESETUP, ST_EUNL1, ST_EUNL2,
    ST_IDENT, ST_SWIN, ST_PBUSY, ST_EBUSY, ST_HOLD, ST_HUNL1, ST_HUNL2,
    ST_HPSETUP, ST_HPBUSY
  } seq_state_e;

  typedef struct packed {
    logic progGo;
    logic chipGo;
    logic sectGo;
    logic listClr;
    logic listAdd;
    logic identMode;
  } path_ctl_t;

  function automatic logic [SECT_W-1:0] sectorOf(input logic [ADDR_W-1:0] a);
    if (a[17])       return a[16] ? SECT_W'(6) : SECT_W'(5);
    else if (a[16])  return SECT_W'(4);
    else if (a[15])  return SECT_W'(3);
    else if (!a[14]) return SECT_W'(0);
    else             return a[13] ? SECT_W'(2) : SECT_W'(1);
  endfunction
endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_WIN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  input  logic              eraseDone,
  input  logic              sectProt,
  input  logic              sectListed,
  input  logic              anyUnprot,
  input  logic              listLive,
  output path_ctl_t         ctl,
  output logic              busy,
  output logic              eraseHold
);
  localparam int WIN_W = $clog2(ERASE_WIN + 1);

  seq_state_e st, nxt;
  logic [WIN_W-1:0] winCnt;
  logic sectMode;
  logic isUnl1, isUnl2, atUnl1;

  assign atUnl1 = addr[CMP_W-1:0] == UNL_ADDR1;
  assign isUnl1 = atUnl1 && wrData == UNL_DATA1;
  assign isUnl2 = addr[CMP_W-1:0] == UNL_ADDR2 && wrData == UNL_DATA2;

  always_comb begin
    nxt = st;
    ctl = '0;
    ctl.identMode = (st == ST_IDENT);
    unique case (st)
      ST_READ, ST_IDENT: if (wrEn) nxt = isUnl1 ? ST_UNL1 : ST_READ;
      ST_UNL1:  if (wrEn) nxt = isUnl2 ? ST_UNL2 : ST_READ;
      ST_UNL2:  if (wrEn) begin
        if (atUnl1 && wrData == OP_PROG)       nxt = ST_PSETUP;
        else if (atUnl1 && wrData == OP_ERASE) nxt = ST_ESETUP;
        else if (atUnl1 && wrData == OP_IDENT) nxt = ST_IDENT;
        else                                   nxt = ST_READ;
      end
      ST_PSETUP: if (wrEn) begin
        ctl.progGo = !sectProt;
        nxt = sectProt ? ST_READ : ST_PBUSY;
      end
      ST_ESETUP: if (wrEn) nxt = isUnl1 ? ST_EUNL1 : ST_READ;
      ST_EUNL1:  if (wrEn) nxt = isUnl2 ? ST_EUNL2 : ST_READ;
      ST_EUNL2:  if (wrEn) begin
        if (wrData == OP_SECT) begin
          ctl.listClr = 1'b1;
          ctl.listAdd = 1'b1;
          nxt = ST_SWIN;
        end else if (atUnl1 && wrData == OP_CHIP && anyUnprot) begin
          ctl.chipGo = 1'b1;
          nxt = ST_EBUSY;
        end else nxt = ST_READ;
      end
      ST_SWIN: begin
        if (wrEn) begin
          ctl.listAdd = (wrData == OP_SECT);
          nxt = (wrData == OP_SECT) ? ST_SWIN : ST_READ;
        end else if (winCnt == '0) begin
          ctl.sectGo = listLive;
          nxt = listLive ? ST_EBUSY : ST_READ;
        end
      end
      ST_PBUSY:  if (progDone) nxt = ST_READ;
      ST_EBUSY: begin
        if (eraseDone) nxt = ST_READ;
        else if (wrEn && sectMode && wrData == OP_HOLD) nxt = ST_HOLD;
      end
      ST_HOLD: if (wrEn) begin
        if (wrData == OP_SECT) nxt = ST_EBUSY;
        else if (isUnl1)       nxt = ST_HUNL1;
      end
      ST_HUNL1: if (wrEn) nxt = isUnl2 ? ST_HUNL2 : ST_HOLD;
      ST_HUNL2: if (wrEn) nxt = (atUnl1 && wrData == OP_PROG) ? ST_HPSETUP : ST_HOLD;
      ST_HPSETUP: if (wrEn) begin
        ctl.progGo = !sectProt && !sectListed;
        nxt = ctl.progGo ? ST_HPBUSY : ST_HOLD;
      end
      ST_HPBUSY: if (progDone) nxt = ST_HOLD;
      default: nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_READ;
      winCnt   <= '0;
      sectMode <= 1'b0;
    end else begin
      st <= nxt;
      if (ctl.listAdd)               winCnt <= WIN_W'(ERASE_WIN - 1);
      else if (winCnt != '0)         winCnt <= winCnt - 1'b1;
      if (ctl.sectGo)                sectMode <= 1'b1;
      else if (ctl.chipGo)           sectMode <= 1'b0;
    end
  end

  assign eraseHold = st inside {ST_HOLD, ST_HUNL1, ST_HUNL2, ST_HPSETUP, ST_HPBUSY};
  assign busy      = eraseHold || st inside {ST_PBUSY, ST_EBUSY};

  AST_PROG_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PBUSY && !progDone) |=> (st == ST_PBUSY)); // R9
  AST_HOLD_ONLY_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    eraseHold |-> sectMode); // R10
  AST_HOLD_NO_EXIT_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HOLD && !wrEn) |=> eraseHold); // R11
endmodule

// File: rtl/flashCmdPath.sv
module flashCmdPath
  import flash_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h04,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hA7
) (
  input  logic                clk,
  input  logic                rstN,
  input  path_ctl_t           ctl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_SECT-1:0] protMask,
  input  logic [DATA_W-1:0]   arrayRdData,
  output logic [DATA_W-1:0]   rdData,
  output logic                sectProt,
  output logic                sectListed,
  output logic                anyUnprot,
  output logic                listLive,
  output logic                progStart,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [DATA_W-1:0]   progData,
  output logic                eraseStart,
  output logic [NUM_SECT-1:0] eraseMask
);
  logic [SECT_W-1:0]   sect;
  logic [NUM_SECT-1:0] eraseList;
  logic [DATA_W-1:0]   identByte;

  assign sect       = sectorOf(addr);
  assign sectProt   = protMask[sect];
  assign sectListed = eraseList[sect];
  assign anyUnprot  = |(~protMask);
  assign listLive   = |(eraseList & ~protMask);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_list
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            eraseList[s] <= 1'b0;
      else if (ctl.chipGo)  eraseList[s] <= !protMask[s];
      else if (ctl.listAdd) eraseList[s] <= (sect == SECT_W'(s)) || (!ctl.listClr && eraseList[s]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progStart  <= 1'b0;
      progAddr   <= '0;
      progData   <= '0;
      eraseStart <= 1'b0;
      eraseMask  <= '0;
    end else begin
      progStart  <= ctl.progGo;
      eraseStart <= ctl.chipGo || ctl.sectGo;
      if (ctl.progGo) begin
        progAddr <= addr;
        progData <= wrData & arrayRdData;
      end
      if (ctl.chipGo)      eraseMask <= ~protMask;
      else if (ctl.sectGo) eraseMask <= eraseList & ~protMask;
    end
  end

  always_comb begin
    unique case (addr[7:0])
      8'h00:   identByte = MFR_CODE;
      8'h01:   identByte = DEV_CODE;
      8'h02:   identByte = {{(DATA_W-1){1'b0}}, sectProt};
      default: identByte = '0;
    endcase
  end

  assign rdData = ctl.identMode ? identByte : arrayRdData;

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> ((progData & ~$past(arrayRdData)) == '0)); // R3
  AST_PROG_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> !$past(protMask[sectorOf(addr)])); // R8
  AST_ERASE_SPARES_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> ((eraseMask & $past(protMask)) == '0)); // R8
  AST_ERASE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (eraseMask != '0)); // R7
endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flash_cmd_pkg::*;
#(
  parameter int                ERASE_WIN = 16,
  parameter logic [DATA_W-1:0] MFR_CODE  = 8'h04,
  parameter logic [DATA_W-1:0] DEV_CODE  = 8'hA7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [DATA_W-1:0]   arrayRdData,
  input  logic [NUM_SECT-1:0] protMask,
  output logic                progStart,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [DATA_W-1:0]   progData,
  input  logic                progDone,
  output logic                eraseStart,
  output logic [NUM_SECT-1:0] eraseMask,
  input  logic                eraseDone,
  output logic                eraseHold,
  output logic                busy
);
  path_ctl_t ctl;
  logic sectProt, sectListed, anyUnprot, listLive;

  flashCmdCtrl #(.ERASE_WIN(ERASE_WIN)) u_ctrl (
    .clk, .rstN, .wrEn, .addr, .wrData, .progDone, .eraseDone,
    .sectProt, .sectListed, .anyUnprot, .listLive,
    .ctl, .busy, .eraseHold
  );

  flashCmdPath #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_path (
    .clk, .rstN, .ctl, .addr, .wrData, .protMask, .arrayRdData, .rdData,
    .sectProt, .sectListed, .anyUnprot, .listLive,
    .progStart, .progAddr, .progData, .eraseStart, .eraseMask
  );
endmodule

// File: tb/sim_flashCmdSeq.sv
module sim_flashCmdSeq;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;
  localparam int PLAT  = 8;
  localparam int ELAT  = 30;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0] wrData = '0, rdData, arrayRdData;
  logic [6:0] protMask = '0, eraseMask;
  logic progStart, eraseStart, eraseHold, busy;
  logic [17:0] progAddr;
  logic [7:0] progData;
  logic progDone = 1'b0, eraseDone = 1'b0;

  int nChk = 0, nFail = 0, progCnt = 0, eraseCnt = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] refMem [0:1023];
  logic memReady = 1'b0;
  int pCnt = 0, eCnt = 0;
  logic [17:0] pA;
  logic [7:0] pD;
  logic [6:0] eM;

  always #(CLK_P/2) clk = ~clk;

  flashCmdSeq u0 (.*);

  function automatic int idx(input logic [17:0] a);
    return {a[17:13], a[4:0]};
  endfunction
  function automatic int refSect(input logic [17:0] a);
    if (a < 18'h04000) return 0;
    if (a < 18'h06000) return 1;
    if (a < 18'h08000) return 2;
    if (a < 18'h10000) return 3;
    return 3 + int'(a >> 16);
  endfunction
  function automatic logic [17:0] addrOf(input int i);
    return {i[9:5], 8'h00, i[4:0]};
  endfunction
  function automatic logic [7:0] seedByte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  assign arrayRdData = mem[idx(addr)];

  // engine models: program and erase, erase pauses while on hold
  always @(posedge clk) begin
    if (!memReady) begin
      for (int i = 0; i < 1024; i++) mem[i] <= seedByte(i);
      memReady <= 1'b1;
    end
    progDone  <= 1'b0;
    eraseDone <= 1'b0;
    if (!rstN) begin
      pCnt <= 0;
      eCnt <= 0;
    end else begin
      if (progStart) begin
        pCnt <= PLAT; pA <= progAddr; pD <= progData; progCnt <= progCnt + 1;
      end else if (pCnt > 0) begin
        pCnt <= pCnt - 1;
        if (pCnt == 1) begin mem[idx(pA)] <= pD; progDone <= 1'b1; end
      end
      if (eraseStart) begin
        eCnt <= ELAT; eM <= eraseMask; eraseCnt <= eraseCnt + 1;
      end else if (eCnt > 0 && !eraseHold) begin
        eCnt <= eCnt - 1;
        if (eCnt == 1) begin
          for (int i = 0; i < 1024; i++) if (eM[refSect(addrOf(i))]) mem[i] <= 8'hFF;
          eraseDone <= 1'b1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [17:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdData, exp);
  endtask

  task automatic progSeq(input logic [17:0] a, input logic [7:0] d);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0); wr(a, d);
  endtask

  task automatic erasePrefix();
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic refErase(input logic [6:0] m);
    for (int i = 0; i < 1024; i++) if (m[refSect(addrOf(i))]) refMem[i] = 8'hFF;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int pc;
    logic [17:0] a;
    logic [7:0] d;
    logic gotE;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) refMem[i] = seedByte(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 eraseHold", eraseHold, 0);
    check("R1 strobes", {progStart, eraseStart}, 0);
    rdChk(18'h10003, refMem[idx(18'h10003)], "R1 read");

    // R2/R3 program strobe and clear-only value
    a = 18'h10004; d = 8'h5A;
    progSeq(a, d);
    check("R2 progStart", progStart, 1);
    check("R2 progAddr", progAddr, a);
    check("R3 progData", progData, refMem[idx(a)] & d);
    check("R9 busy", busy, 1);
    waitIdle();
    refMem[idx(a)] &= d;
    rdChk(a, refMem[idx(a)], "R3 readback");

    // R4 broken unlock sequence
    pc = progCnt;
    wr(18'h00555, 8'hAA); wr(18'h002AB, 8'h55); wr(18'h00555, 8'hA0); wr(18'h10005, 8'h00);
    repeat (PLAT + 3) @(negedge clk);
    check("R4 no program", progCnt, pc);
    rdChk(18'h10005, refMem[idx(18'h10005)], "R4 array");

    // R5 identifier mode
    protMask = 7'b0100000;
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h90);
    rdChk(18'h00000, 8'h04, "R5 maker");
    rdChk(18'h00001, 8'hA7, "R5 device");
    rdChk(18'h20002, 8'h01, "R5 locked");
    rdChk(18'h30002, 8'h00, "R5 open");
    wr(18'h00000, 8'hF0);
    rdChk(18'h20003, refMem[idx(18'h20003)], "R5 exit");

    // R8 program to a locked sector
    pc = progCnt;
    progSeq(18'h20001, 8'h00);
    repeat (PLAT + 3) @(negedge clk);
    check("R8 no program", progCnt, pc);
    rdChk(18'h20001, refMem[idx(18'h20001)], "R8 array");

    // R9 writes ignored while busy
    pc = progCnt;
    progSeq(18'h00003, 8'h0F);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
    waitIdle();
    refMem[idx(18'h00003)] &= 8'h0F;
    wr(18'h00555, 8'hA0); wr(18'h00004, 8'h00);
    repeat (PLAT + 3) @(negedge clk);
    check("R9 one program", progCnt, pc + 1);
    rdChk(18'h00004, refMem[idx(18'h00004)], "R9 array");

    // R6 chip erase, R10 hold ignored in chip erase
    erasePrefix(); wr(18'h00555, 8'h10);
    check("R6 eraseStart", eraseStart, 1);
    check("R6 eraseMask", eraseMask, 7'b1011111);
    wr(18'h00000, 8'hB0);
    check("R10 no hold in chip erase", eraseHold, 0);
    waitIdle();
    refErase(7'b1011111);
    rdChk(18'h00003, 8'hFF, "R6 erased");
    rdChk(18'h20003, refMem[idx(18'h20003)], "R6 locked kept");

    // R7 multi-sector erase with accumulation window
    pc = eraseCnt;
    erasePrefix(); wr(18'h10000, 8'h30); wr(18'h06000, 8'h30); wr(18'h20000, 8'h30);
    gotE = 1'b0;
    for (int k = 0; k < WIN + 10 && !gotE; k++) begin
      @(negedge clk);
      if (eraseStart) begin gotE = 1'b1; check("R7 mask", eraseMask, 7'b0010100); end
    end
    check("R7 started", gotE, 1);
    waitIdle();
    refErase(7'b0010100);
    erasePrefix(); wr(18'h08000, 8'h30); wr(18'h00000, 8'hF0);
    repeat (WIN + 5) @(negedge clk);
    check("R7 cancelled", eraseCnt, pc + 1);

    // R10/R11 suspend, program elsewhere, resume
    progSeq(18'h08001, 8'h12); waitIdle();
    refMem[idx(18'h08001)] &= 8'h12;
    rdChk(18'h08001, refMem[idx(18'h08001)], "R11 pre");
    erasePrefix(); wr(18'h08000, 8'h30);
    repeat (WIN + 4) @(negedge clk);
    wr(18'h00000, 8'hB0);
    check("R10 hold", eraseHold, 1);
    pc = progCnt;
    progSeq(18'h08002, 8'h00);
    repeat (PLAT + 3) @(negedge clk);
    check("R11 listed rejected", progCnt, pc);
    progSeq(18'h00005, 8'h3C);
    repeat (PLAT + 4) @(negedge clk);
    check("R11 program ran", progCnt, pc + 1);
    check("R11 still held", eraseHold, 1);
    refMem[idx(18'h00005)] &= 8'h3C;
    rdChk(18'h00005, refMem[idx(18'h00005)], "R11 read during hold");
    wr(18'h00000, 8'h30);
    check("R11 resumed", eraseHold, 0);
    waitIdle();
    refErase(7'b0001000);
    rdChk(18'h08001, 8'hFF, "R11 erase finished");

    // R12 reset aborts
    progSeq(18'h10010, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 busy", busy, 0);
    check("R12 hold", eraseHold, 0);
    repeat (PLAT + 2) @(negedge clk);
    rdChk(18'h10010, refMem[idx(18'h10010)], "R12 array");

    // random programs, broken sequences and lock masks
    for (int it = 0; it < 60; it++) begin
      int op;
      logic [4:0] hi, lo;
      op = $urandom_range(0, 2);
      hi = 5'($urandom); lo = 5'($urandom);
      a = {hi, 8'h00, lo}; d = 8'($urandom);
      protMask = 7'($urandom);
      pc = progCnt;
      if (op == 0) begin
        progSeq(a, d);
        repeat (PLAT + 3) @(negedge clk);
        if (!protMask[refSect(a)]) refMem[idx(a)] &= d;
        check("R8 random start", progCnt, pc + (protMask[refSect(a)] ? 0 : 1));
        rdChk(a, refMem[idx(a)], "R2 random program");
      end else if (op == 1) begin
        wr(18'h00555, 8'hAA); wr(18'h00555, 8'h55); wr(18'h00555, 8'hA0); wr(a, d);
        repeat (PLAT + 3) @(negedge clk);
        check("R4 random broken", progCnt, pc);
        rdChk(a, refMem[idx(a)], "R4 random array");
      end else begin
        rdChk(a, refMem[idx(a)], "R1 random read");
      end
    end
    finishRun();
  end
endmodule